// File: doc/BRIEF.md
# Split-Word 64-bit Free-Running Counter

This block holds a 64-bit up-counter that software sees as two 32-bit words on a simple register bus. Software can load either word while the counter is halted. A control register carries a run bit. While that bit is set the counter advances by one on every clock and wraps through zero after the all-ones value. The live 64-bit value is also driven out as a port for neighbouring timer logic.

Writes to the two count words and to the control register do not take effect at once. Each one travels through a fixed apply delay that stands in for a clock-domain crossing. On the cycle the value lands, a matching flag in a write-status register turns on. The flag stays on until software writes a one to that bit position. Software waits on the flag before it relies on the new value.

Reads are combinational from the current state. Software obtains a consistent 64-bit value by reading the upper word, the lower word and the upper word again, and retries if the two upper values differ.

Top module: `wide_tick_counter`

## Requirements
- R1: After reset the count is zero and the counter is halted. Reads of offsets 0x100, 0x104, 0x110 and 0x240 all return zero.
- R2: While bit 8 of the control register (offset 0x240) is one, the count rises by exactly one per clock. A read of 0x240 returns the run bit in bit 8 and zeros elsewhere. `count_out` always equals the value the two word reads return.
- R3: A write to offset 0x100 replaces count bits 31:0, and a write to 0x104 replaces bits 63:32, when that write is applied while the counter is halted. A word write applied while the counter runs is discarded, leaves the count unchanged and sets no flag. While the counter is halted and no word write is applied, the count holds.
- R4: A write accepted on clock edge n takes effect on edge n+APPLY_LAT (default 3). On that same edge, bit 0 (lower word), bit 1 (upper word) or bit 2 (control) of the write-status register at 0x110 becomes one. A status bit never turns on at any other time.
- R5: Writing 0x110 clears each status bit whose data bit is one and leaves the other status bits as they were.
- R6: A write to any offset other than 0x100, 0x104, 0x110 and 0x240 sets no status bit and changes neither the count nor the run bit.
- R7: If a carry moves from the lower word into the upper word between reads, the sequence upper, lower, upper returns two different upper values, and the second one is the first plus one.
- R8: The count wraps from 2^64-1 to zero and keeps running.
- R9: If a write-one-to-clear of a status bit occurs on the same edge that an applied write sets that bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and the counter |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe; one write per cycle in which it is high |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| count_out | output | 64 | Live 64-bit count |

## Verification
The assertions assume that reset is held for at least one edge before any bus traffic. They also assume that `bus_wr`, `bus_addr` and `bus_wdata` have known values at every sampling edge. The bench meets both assumptions: it drives every input from a single task just after the falling edge and keeps reset high for two edges first. It issues at most one write per cycle, which matches the single-stream apply path that the status flags depend on. It times the carry-read and set-versus-clear cases to exact edges, so that the outcome does not depend on chance.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 2 * WORD_W;
    localparam int ADDR_W = 12;
    localparam int ST_W   = 3;
    localparam int RUN_BIT = 8;

    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_WSTAT  = 12'h110;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h240;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_LO   = 2'd1,
        TGT_HI   = 2'd2,
        TGT_CTRL = 2'd3
    } wr_tgt_e;

    typedef struct packed {
        wr_tgt_e           tgt;
        logic [WORD_W-1:0] data;
    } pend_wr_t;

    function automatic wr_tgt_e decode_tgt(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_CNT_LO: return TGT_LO;
            OFS_CNT_HI: return TGT_HI;
            OFS_CTRL:   return TGT_CTRL;
            default:    return TGT_NONE;
        endcase
    endfunction

    function automatic logic [ST_W-1:0] tgt_flag(input wr_tgt_e t);
        case (t)
            TGT_LO:   return 3'b001;
            TGT_HI:   return 3'b010;
            TGT_CTRL: return 3'b100;
            default:  return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/wtc_apply_pipe.sv
module wtc_apply_pipe
    import wtc_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  pend_wr_t in_wr,
    output pend_wr_t out_wr
);

    pend_wr_t [LAT-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= in_wr;
            for (int i = 1; i < LAT; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign out_wr = stage_q[LAT-1];

endmodule

// File: rtl/wtc_count_core.sv
module wtc_count_core
    import wtc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  pend_wr_t        apply_wr,
    output logic [CNT_W-1:0] cnt_q,
    output logic            run_q,
    output logic [ST_W-1:0] done_mask
);

    logic [CNT_W-1:0] cnt_d;
    logic             run_d;
    logic             word_hit;

    assign word_hit = (apply_wr.tgt == TGT_LO) || (apply_wr.tgt == TGT_HI);

    always_comb begin
        cnt_d     = run_q ? cnt_q + CNT_W'(1) : cnt_q;
        run_d     = run_q;
        done_mask = '0;
        case (apply_wr.tgt)
            TGT_LO: begin
                if (!run_q) begin
                    cnt_d[WORD_W-1:0] = apply_wr.data;
                    done_mask         = tgt_flag(TGT_LO);
                end
            end
            TGT_HI: begin
                if (!run_q) begin
                    cnt_d[CNT_W-1:WORD_W] = apply_wr.data;
                    done_mask             = tgt_flag(TGT_HI);
                end
            end
            TGT_CTRL: begin
                run_d     = apply_wr.data[RUN_BIT];
                done_mask = tgt_flag(TGT_CTRL);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end

    AST_RUN_STEP: assert property (@(posedge clk) disable iff (rst)
        run_q |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !word_hit) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/wtc_wstatus.sv
module wtc_wstatus
    import wtc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] set_mask,
    input  logic [ST_W-1:0] clr_mask,
    output logic [ST_W-1:0] flags_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_mask) | set_mask;
        end
    end

    AST_STICKY_FLAGS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(flags_q) & ~$past(clr_mask)) & ~flags_q) == '0)); // R5

    AST_SET_BY_APPLY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(set_mask)) == '0)); // R4

    AST_ONE_APPLY: assert property (@(posedge clk) disable iff (rst)
        $onehot0(set_mask)); // R4

endmodule

// File: rtl/wide_tick_counter.sv
module wide_tick_counter
    import wtc_pkg::*;
#(
    parameter int APPLY_LAT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [63:0]       count_out
);

    pend_wr_t         in_wr;
    pend_wr_t         apply_wr;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [ST_W-1:0]  done_mask;
    logic [ST_W-1:0]  clr_mask;
    logic [ST_W-1:0]  flags_q;

    always_comb begin
        in_wr.tgt  = bus_wr ? decode_tgt(bus_addr) : TGT_NONE;
        in_wr.data = bus_wdata;
    end

    assign clr_mask = (bus_wr && (bus_addr == OFS_WSTAT)) ? bus_wdata[ST_W-1:0] : '0;

    wtc_apply_pipe #(.LAT(APPLY_LAT)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .in_wr  (in_wr),
        .out_wr (apply_wr)
    );

    wtc_count_core u_core (
        .clk       (clk),
        .rst       (rst),
        .apply_wr  (apply_wr),
        .cnt_q     (cnt_q),
        .run_q     (run_q),
        .done_mask (done_mask)
    );

    wtc_wstatus u_status (
        .clk      (clk),
        .rst      (rst),
        .set_mask (done_mask),
        .clr_mask (clr_mask),
        .flags_q  (flags_q)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CNT_LO: bus_rdata = cnt_q[WORD_W-1:0];
            OFS_CNT_HI: bus_rdata = cnt_q[CNT_W-1:WORD_W];
            OFS_WSTAT:  bus_rdata[ST_W-1:0] = flags_q;
            OFS_CTRL:   bus_rdata[RUN_BIT] = run_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign count_out = cnt_q;

    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (apply_wr.tgt != TGT_CTRL) |=> (run_q == $past(run_q))); // R6

endmodule

// File: tb/wide_tick_counter_tb.sv
module wide_tick_counter_tb;

    localparam int CLK_P = 10;
    localparam int LAT   = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] count_out;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int          due;
        int          kind;
        logic [31:0] d;
    } pend_t;

    pend_t       q[$];
    logic [63:0] m_cnt;
    bit          m_run;
    logic [2:0]  m_st;
    int          edge_no;

    always #(CLK_P/2) clk = ~clk;

    wide_tick_counter #(.APPLY_LAT(LAT)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count_out (count_out)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [11:0] a);
        case (a)
            12'h100: return m_cnt[31:0];
            12'h104: return m_cnt[63:32];
            12'h110: return {29'd0, m_st};
            12'h240: return m_run ? 32'h100 : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_update(input bit wr, input logic [11:0] a, input logic [31:0] d);
        logic [63:0] nc;
        bit          nr;
        logic [2:0]  ns;
        pend_t       p;
        int          k;
        edge_no++;
        nc = m_run ? m_cnt + 64'd1 : m_cnt;
        nr = m_run;
        ns = m_st;
        if (wr && a == 12'h110) ns = ns & ~d[2:0];
        if (q.size() > 0 && q[0].due == edge_no) begin
            p = q.pop_front();
            if (p.kind == 1 && !m_run) begin nc[31:0]  = p.d; ns[0] = 1'b1; end
            if (p.kind == 2 && !m_run) begin nc[63:32] = p.d; ns[1] = 1'b1; end
            if (p.kind == 3) begin nr = p.d[8]; ns[2] = 1'b1; end
        end
        k = (a == 12'h100) ? 1 : (a == 12'h104) ? 2 : (a == 12'h240) ? 3 : 0;
        if (wr && k != 0) q.push_back('{due: edge_no + LAT, kind: k, d: d});
        m_cnt = nc;
        m_run = nr;
        m_st  = ns;
    endtask

    task automatic step(input bit wr, input logic [11:0] a, input logic [31:0] d);
        bus_wr = wr;
        bus_addr = a;
        bus_wdata = d;
        model_update(wr, a, d);
        @(posedge clk);
        #1;
        chk(count_out == m_cnt, "R2 count_out vs model", count_out, m_cnt);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 12'h000, 32'h0);
    endtask

    task automatic rd(input logic [11:0] a, input string req, output logic [31:0] v);
        bus_wr = 1'b0;
        bus_addr = a;
        #1;
        v = bus_rdata;
        chk(v == model_read(a), req, v, model_read(a));
        step(1'b0, a, 32'h0);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v, h1, lo, h2;
        logic [63:0] held;
        bit saw_carry;
        m_cnt = '0; m_run = 0; m_st = '0; edge_no = 0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(12'h100, "R1 lower after reset", v);
        rd(12'h104, "R1 upper after reset", v);
        rd(12'h110, "R1 status after reset", v);
        rd(12'h240, "R1 control after reset", v);
        chk(count_out == 64'd0, "R1 count_out after reset", count_out, 64'd0);

        // R4 lower word apply timing
        step(1'b1, 12'h100, 32'hFFFF_FFFD);
        for (int i = 0; i < LAT; i++) rd(12'h110, "R4 status during apply", v);
        rd(12'h100, "R3 lower loaded", v);
        chk(v == 32'hFFFF_FFFD, "R3 lower value", v, 32'hFFFF_FFFD);

        // R3 upper word load
        step(1'b1, 12'h104, 32'h5);
        idle(LAT);
        rd(12'h104, "R3 upper loaded", v);
        chk(v == 32'h5, "R3 upper value", v, 32'h5);
        rd(12'h110, "R4 both word flags", v);
        chk(v == 32'h3, "R4 flags 0 and 1", v, 32'h3);

        // R5 write-one-to-clear
        step(1'b1, 12'h110, 32'h1);
        rd(12'h110, "R5 clear bit 0 only", v);
        chk(v == 32'h2, "R5 bit 1 kept", v, 32'h2);
        step(1'b1, 12'h110, 32'h4);
        rd(12'h110, "R5 clearing unset bit", v);
        step(1'b1, 12'h110, 32'h2);
        rd(12'h110, "R5 all clear", v);
        chk(v == 32'h0, "R5 status zero", v, 32'h0);

        // R6 unmapped writes
        step(1'b1, 12'h108, 32'hFFFF_FFFF);
        step(1'b1, 12'h300, 32'hFFFF_FFFF);
        step(1'b1, 12'h244, 32'h0000_0100);
        idle(LAT + 1);
        rd(12'h110, "R6 no flag from unmapped", v);
        rd(12'h240, "R6 run unchanged", v);
        rd(12'h100, "R6 lower unchanged", v);
        rd(12'h104, "R6 upper unchanged", v);

        // R9 set wins over simultaneous clear
        step(1'b1, 12'h100, 32'h1234_5678);
        idle(LAT - 1);
        step(1'b1, 12'h110, 32'h7);
        rd(12'h110, "R9 set wins", v);
        chk(v == 32'h1, "R9 bit 0 set", v, 32'h1);
        step(1'b1, 12'h110, 32'h7);

        // R7 carry detection by upper-lower-upper reads
        step(1'b1, 12'h100, 32'hFFFF_FFF9);
        step(1'b1, 12'h104, 32'h7);
        idle(LAT);
        step(1'b1, 12'h110, 32'h7);
        step(1'b1, 12'h240, 32'h100);
        idle(LAT - 1);
        saw_carry = 0;
        for (int t = 0; t < 4; t++) begin
            rd(12'h104, "R7 first upper", h1);
            rd(12'h100, "R7 lower", lo);
            rd(12'h104, "R7 second upper", h2);
            if (h1 != h2) begin
                saw_carry = 1;
                chk(h2 == h1 + 1, "R7 upper advanced by one", h2, h1 + 1);
            end
        end
        chk(saw_carry, "R7 carry observed", saw_carry, 1);
        rd(12'h240, "R2 run bit reads back", v);
        chk(v == 32'h100, "R2 control value", v, 32'h100);

        // R3 word write while running is dropped
        step(1'b1, 12'h110, 32'h7);
        step(1'b1, 12'h100, 32'h0);
        idle(LAT + 1);
        rd(12'h110, "R3 no flag when running", v);
        chk(v == 32'h0, "R3 dropped write", v, 32'h0);

        // R3 halt holds the count
        step(1'b1, 12'h240, 32'h0);
        idle(LAT + 1);
        held = count_out;
        idle(3);
        chk(count_out == held, "R3 halted count holds", count_out, held);

        // R8 wrap at 2^64
        step(1'b1, 12'h100, 32'hFFFF_FFFE);
        step(1'b1, 12'h104, 32'hFFFF_FFFF);
        idle(LAT);
        step(1'b1, 12'h240, 32'h100);
        idle(LAT + 4);
        chk(count_out < 64'd16, "R8 wrapped to small value", count_out, m_cnt);
        rd(12'h104, "R8 upper after wrap", v);
        chk(v == 32'h0, "R8 upper zero", v, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule